// File: doc/BRIEF.md
# L2 Allocation Policy Controller

This block sits between the miss stream of a first-level cache and a second-level cache. For every request it answers four questions: whether the L2 tags are consulted, whether a miss installs a new line, whether the access must be sent around the L2 as cache-inhibited, and whether a write also goes out on the system bus. It also names the coherence state that the line is to record. Tag arrays, data RAMs and the bus protocol belong to neighbouring blocks. The controller only issues decisions.

Software programs a small control word. That word turns the cache on, limits allocation to instruction traffic or to data traffic (setting both limits locks the cache), selects write-through or write-back, and starts a global invalidate. The controller walks the status array one index per cycle during an invalidate, and shows a busy flag while the walk runs. Two kinds of control write are unsafe: turning on write-through while the cache is on, and starting an invalidate while the cache is on. The controller refuses both and raises an error pulse.

Top module: `l2_alloc_policy`

## Requirements
- R1: After reset the cache is disabled, all modes are clear, and every output is 0.
- R2: While the cache is disabled or an invalidate walk is busy, the response to a request is lookup=0, allocate=0, bypass=1, bus-write equal to the request's write bit, and state 00.
- R3: Control word bits are [0] enable, [1] data-only, [2] instruction-only, [3] write-through and [4] invalidate-start. A control write takes effect from the next request. A request presented in the same cycle as the write is decided with the previous settings.
- R4: When the cache is enabled with no mode restriction, every request has lookup=1 and bypass=0. A miss sets allocate=1 and a hit sets allocate=0. State codes are 00 for no change, 01 for exclusive and 10 for modified. A read miss records 01 and a read hit records 00.
- R5: In data-only mode, an instruction miss bypasses with lookup=0 and allocate=0. An instruction hit is served with lookup=1 and no allocation. Data requests allocate as usual.
- R6: In instruction-only mode, a data miss (read or write) bypasses with lookup=0 and allocate=0. A write bypass sets bus-write=1. A data hit, including a write hit, is served from the L2.
- R7: With both data-only and instruction-only set, no request ever allocates. A write hit still has lookup=1 and records a new state.
- R8: With write-through clear, a write served by the L2 has bus-write=0 and records modified (10).
- R9: With write-through set, a write served by the L2 has bus-write=1 and records exclusive (01).
- R10: Turning on write-through while the cache is enabled is ignored. cfg_err is high in the cycle after that control write. Other fields of the same write still apply.
- R11: An accepted invalidate raises inval_busy and inval_clr from the next cycle. inval_idx then steps through 0 to DEPTH-1, one index per cycle, after which inval_busy falls.
- R12: An invalidate start is refused when the cache is enabled, when the same write enables it, or when a walk is already running. A refused start pulses cfg_err and leaves inval_busy low.
- R13: rsp_valid is high exactly one cycle after each request. The response fields are 0 when rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_word | input | 5 | Control word (bit map in R3) |
| req_valid | input | 1 | Request present |
| req_instr | input | 1 | 1 = instruction request, 0 = data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_hit | input | 1 | Tag lookup result for the request |
| rsp_valid | output | 1 | Decision valid |
| rsp_lookup | output | 1 | Consult the L2 |
| rsp_alloc | output | 1 | Install a line on the miss |
| rsp_bypass | output | 1 | Treat as cache-inhibited |
| rsp_buswr | output | 1 | Issue the write on the system bus |
| rsp_state | output | 2 | State to record (00 none, 01 exclusive, 10 modified) |
| cfg_err | output | 1 | Refused control write, one-cycle pulse |
| inval_busy | output | 1 | Global invalidate in progress |
| inval_clr | output | 1 | Clear strobe for the status entry at inval_idx |
| inval_idx | output | $clog2(DEPTH) | Status index being cleared |

## Verification
The bench builds the controller with DEPTH=8. With that depth the whole invalidate walk, including the final index and the fall of the busy flag, fits in a few cycles and can be checked index by index. The short walk also leaves time, while it is still running, to enable the cache and send a request. That request shows that the busy flag alone forces a bypass. Every mode combination is then stepped through: hits, misses, reads and writes, under both write policies.

// File: rtl/l2ap_pkg.sv
package l2ap_pkg;

  localparam int CFG_W     = 5;
  localparam int CB_EN     = 0;
  localparam int CB_DONLY  = 1;
  localparam int CB_IONLY  = 2;
  localparam int CB_WT     = 3;
  localparam int CB_INV    = 4;

  typedef enum logic [1:0] {
    ST_NONE = 2'b00,
    ST_EXCL = 2'b01,
    ST_MOD  = 2'b10
  } l2ap_state_e;

  typedef struct packed {
    logic en;
    logic donly;
    logic ionly;
    logic wt;
  } l2ap_cfg_t;

  typedef struct packed {
    logic        lookup;
    logic        alloc;
    logic        bypass;
    logic        buswr;
    l2ap_state_e st;
  } l2ap_dec_t;

  // A request class that the active mode excludes from allocation
  function automatic logic l2ap_restricted(l2ap_cfg_t c, logic instr);
    return (instr & c.donly) | (~instr & c.ionly);
  endfunction

  // Full policy decision for one request
  function automatic l2ap_dec_t l2ap_decide(l2ap_cfg_t c, logic busy,
                                            logic instr, logic write, logic hit);
    l2ap_dec_t d;
    d = '0;
    d.st = ST_NONE;
    if (!c.en || busy) begin
      d.bypass = 1'b1;
      d.buswr  = write;
    end else if (l2ap_restricted(c, instr) && !hit) begin
      d.bypass = 1'b1;
      d.buswr  = write;
    end else begin
      d.lookup = 1'b1;
      d.alloc  = ~hit;
      d.buswr  = write & c.wt;
      if (write)     d.st = c.wt ? ST_EXCL : ST_MOD;
      else if (!hit) d.st = ST_EXCL;
      else           d.st = ST_NONE;
    end
    return d;
  endfunction

endpackage

// File: rtl/l2ap_cfg_reg.sv
module l2ap_cfg_reg
  import l2ap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             inval_busy,
  output l2ap_cfg_t        act_cfg,
  output logic             inval_start,
  output logic             cfg_err
);

  l2ap_cfg_t act_q;
  logic      err_q;
  logic      wt_refused;
  logic      inv_req;
  logic      inv_refused;

  assign wt_refused  = cfg_wr & cfg_word[CB_WT] & ~act_q.wt & act_q.en;
  assign inv_req     = cfg_wr & cfg_word[CB_INV];
  assign inv_refused = inv_req & (act_q.en | cfg_word[CB_EN] | inval_busy);
  assign inval_start = inv_req & ~inv_refused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= wt_refused | inv_refused;
      if (cfg_wr) begin
        act_q.en    <= cfg_word[CB_EN];
        act_q.donly <= cfg_word[CB_DONLY];
        act_q.ionly <= cfg_word[CB_IONLY];
        act_q.wt    <= wt_refused ? act_q.wt : cfg_word[CB_WT];
      end
    end
  end

  assign act_cfg = act_q;
  assign cfg_err = err_q;

  // R10: an error pulse only ever follows a control write
  assert_err_follows_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_wr));

  // R10: write-through may only turn on while the cache was off
  assert_wt_set_only_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_cfg.wt) |-> !$past(act_cfg.en));

endmodule

// File: rtl/l2ap_inval_walk.sv
module l2ap_inval_walk #(
  parameter int DEPTH = 1024,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             clr,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic             at_last;

  assign at_last = (idx_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (busy_q) begin
      busy_q <= ~at_last;
      idx_q  <= at_last ? '0 : idx_q + 1'b1;
    end else if (start) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end
  end

  assign busy = busy_q;
  assign clr  = busy_q;
  assign idx  = idx_q;

  // R11: the walk ends only after the last index has been cleared
  assert_walk_ends_at_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(idx) == LAST);

  // R11: every walk begins at index 0
  assert_walk_starts_at_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> idx == '0);

  // R12: the configuration stage never starts a walk over a running one
  assert_no_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

endmodule

// File: rtl/l2ap_decide.sv
module l2ap_decide
  import l2ap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  l2ap_cfg_t act_cfg,
  input  logic      busy,
  input  logic      req_valid,
  input  logic      req_instr,
  input  logic      req_write,
  input  logic      req_hit,
  output logic      rsp_valid,
  output l2ap_dec_t rsp
);

  l2ap_dec_t dec_now;
  l2ap_dec_t rsp_q;
  logic      vld_q;

  assign dec_now = l2ap_decide(act_cfg, busy, req_instr, req_write, req_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      rsp_q <= '0;
    end else begin
      vld_q <= req_valid;
      rsp_q <= req_valid ? dec_now : '0;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp       = rsp_q;

  // R4: an allocation is always a lookup that does not bypass
  assert_alloc_needs_lookup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp.alloc |-> rsp.lookup && !rsp.bypass);

  // R8: a line marked modified never also goes to the bus
  assert_mod_no_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp.st == ST_MOD |-> !rsp.buswr);

  // R2: a request seen while the walk was busy bypassed
  assert_busy_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && $past(busy) |-> rsp.bypass && !rsp.lookup);

  // R13: a response exists only for a request one cycle earlier
  assert_rsp_follows_req_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  // R13: fields are quiet without a response
  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> rsp == '0);

endmodule

// File: rtl/l2_alloc_policy.sv
module l2_alloc_policy
  import l2ap_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [4:0]       cfg_word,
  input  logic             req_valid,
  input  logic             req_instr,
  input  logic             req_write,
  input  logic             req_hit,
  output logic             rsp_valid,
  output logic             rsp_lookup,
  output logic             rsp_alloc,
  output logic             rsp_bypass,
  output logic             rsp_buswr,
  output logic [1:0]       rsp_state,
  output logic             cfg_err,
  output logic             inval_busy,
  output logic             inval_clr,
  output logic [IDX_W-1:0] inval_idx
);

  l2ap_cfg_t act_cfg;
  logic      inval_start;
  l2ap_dec_t rsp;

  l2ap_cfg_reg u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_word    (cfg_word),
    .inval_busy  (inval_busy),
    .act_cfg     (act_cfg),
    .inval_start (inval_start),
    .cfg_err     (cfg_err)
  );

  l2ap_inval_walk #(.DEPTH(DEPTH)) u_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (inval_start),
    .busy  (inval_busy),
    .clr   (inval_clr),
    .idx   (inval_idx)
  );

  l2ap_decide u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_cfg   (act_cfg),
    .busy      (inval_busy),
    .req_valid (req_valid),
    .req_instr (req_instr),
    .req_write (req_write),
    .req_hit   (req_hit),
    .rsp_valid (rsp_valid),
    .rsp       (rsp)
  );

  assign rsp_lookup = rsp.lookup;
  assign rsp_alloc  = rsp.alloc;
  assign rsp_bypass = rsp.bypass;
  assign rsp_buswr  = rsp.buswr;
  assign rsp_state  = rsp.st;

  // R7: with both restrictions active, no response ever allocates
  assert_locked_no_alloc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && $past(act_cfg.donly && act_cfg.ionly) |-> !rsp_alloc);

  // R12: an invalidate never runs while the cache was enabled at its start
  assert_inval_only_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inval_busy) |-> !$past(act_cfg.en));

endmodule

// File: tb/l2_alloc_policy_bench.sv
module l2_alloc_policy_bench;

  localparam int DEPTH = 8;
  localparam int IW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [4:0]    cfg_word = '0;
  logic          req_valid = 1'b0, req_instr = 1'b0, req_write = 1'b0, req_hit = 1'b0;
  logic          rsp_valid, rsp_lookup, rsp_alloc, rsp_bypass, rsp_buswr;
  logic [1:0]    rsp_state;
  logic          cfg_err, inval_busy, inval_clr;
  logic [IW-1:0] inval_idx;

  always #5 clk = ~clk;

  l2_alloc_policy #(.DEPTH(DEPTH)) u_l2_alloc_policy (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .req_valid(req_valid), .req_instr(req_instr), .req_write(req_write), .req_hit(req_hit),
    .rsp_valid(rsp_valid), .rsp_lookup(rsp_lookup), .rsp_alloc(rsp_alloc),
    .rsp_bypass(rsp_bypass), .rsp_buswr(rsp_buswr), .rsp_state(rsp_state),
    .cfg_err(cfg_err), .inval_busy(inval_busy), .inval_clr(inval_clr), .inval_idx(inval_idx)
  );

  typedef struct packed {
    logic       lk, al, bp, bw;
    logic [1:0] st;
    logic [7:0] rq;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;

  // Bench view of the active settings
  logic m_en = 0, m_donly = 0, m_ionly = 0, m_wt = 0, m_busy = 0;

  localparam logic [4:0] W_EN = 5'b00001, W_DO = 5'b00010, W_IO = 5'b00100,
                         W_WT = 5'b01000, W_INV = 5'b10000;

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic exp_t model(logic instr, logic write, logic hit, int rq);
    exp_t e;
    logic served, blocked;
    e = '0;
    e.rq = rq[7:0];
    blocked = (instr ? m_donly : m_ionly) && !hit;
    served  = m_en && !m_busy && !blocked;
    if (!served) begin
      e.bp = 1'b1;
      e.bw = write;
    end else begin
      e.lk = 1'b1;
      e.al = !hit;
      e.bw = write && m_wt;
      if (write)    e.st = m_wt ? 2'b01 : 2'b10;
      else if (hit) e.st = 2'b00;
      else          e.st = 2'b01;
    end
    return e;
  endfunction

  // Monitor: compare each response with the oldest expected item
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R13 unexpected response actual=1 expected=0 at %0t", $time);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check($sformatf("R%0d lookup", e.rq), 32'(rsp_lookup), 32'(e.lk));
        check($sformatf("R%0d alloc",  e.rq), 32'(rsp_alloc),  32'(e.al));
        check($sformatf("R%0d bypass", e.rq), 32'(rsp_bypass), 32'(e.bp));
        check($sformatf("R%0d buswr",  e.rq), 32'(rsp_buswr),  32'(e.bw));
        check($sformatf("R%0d state",  e.rq), 32'(rsp_state),  32'(e.st));
      end
    end
  end

  task automatic send(logic instr, logic write, logic hit, int rq);
    @(negedge clk);
    exp_q.push_back(model(instr, write, hit, rq));
    req_valid = 1; req_instr = instr; req_write = write; req_hit = hit;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic write_cfg(logic [4:0] w, string rq);
    logic e_err;
    e_err = (w[3] && !m_wt && m_en) || (w[4] && (m_en || w[0] || m_busy));
    @(negedge clk);
    cfg_wr = 1; cfg_word = w;
    @(negedge clk);
    cfg_wr = 0;
    check({rq, " cfg_err"}, 32'(cfg_err), 32'(e_err));
    m_en = w[0]; m_donly = w[1]; m_ionly = w[2];
    if (!(w[3] && !m_wt && m_en === 1'b0 ? 1'b0 : (w[3] && !m_wt && e_err && !w[4]))) m_wt = w[3];
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 bypass", 32'(rsp_bypass), 0);
    check("R1 busy", 32'(inval_busy), 0);
    check("R1 cfg_err", 32'(cfg_err), 0);
    send(0, 0, 0, 1);                     // R1: disabled after reset -> bypass

    // R2: disabled cache bypasses
    send(0, 1, 1, 2);
    send(1, 0, 1, 2);

    // R3: request in the same cycle as the enabling write sees old settings
    @(negedge clk);
    exp_q.push_back(model(0, 0, 0, 3));
    cfg_wr = 1; cfg_word = W_EN;
    req_valid = 1; req_instr = 0; req_write = 0; req_hit = 0;
    @(negedge clk);
    cfg_wr = 0; req_valid = 0;
    m_en = 1;
    send(0, 0, 0, 3);

    // R4 / R8: normal write-back operation
    send(0, 0, 0, 4);
    send(0, 0, 1, 4);
    send(1, 0, 0, 4);
    send(0, 1, 1, 8);
    send(0, 1, 0, 8);

    // R10: write-through while enabled is refused
    @(negedge clk);
    cfg_wr = 1; cfg_word = W_EN | W_WT;
    @(negedge clk);
    cfg_wr = 0;
    check("R10 cfg_err", 32'(cfg_err), 1);
    send(0, 1, 1, 10);                    // still write-back: modified, no bus write

    // R9: write-through set while disabled
    write_cfg(5'b0, "R9");
    write_cfg(W_EN | W_WT, "R9");
    send(0, 1, 1, 9);
    send(0, 1, 0, 9);
    send(1, 0, 0, 9);

    // R5: data-only
    write_cfg(W_EN | W_DO, "R5");
    send(1, 0, 0, 5);
    send(1, 0, 1, 5);
    send(0, 0, 0, 5);

    // R6: instruction-only
    write_cfg(W_EN | W_IO, "R6");
    send(0, 0, 0, 6);
    send(0, 1, 0, 6);
    send(0, 1, 1, 6);
    send(1, 0, 0, 6);

    // R7: locked
    write_cfg(W_EN | W_DO | W_IO, "R7");
    send(1, 0, 0, 7);
    send(0, 1, 0, 7);
    send(0, 1, 1, 7);
    send(1, 0, 1, 7);

    // R12: invalidate refused while enabled
    write_cfg(W_EN | W_INV, "R12");
    check("R12 busy", 32'(inval_busy), 0);
    @(negedge clk);
    check("R12 busy later", 32'(inval_busy), 0);

    // R11: accepted invalidate walks every index
    write_cfg(5'b0, "R11");
    @(negedge clk);
    cfg_wr = 1; cfg_word = W_INV;
    @(negedge clk);
    cfg_wr = 0;
    check("R11 cfg_err", 32'(cfg_err), 0);
    m_busy = 1;
    for (int i = 0; i < DEPTH; i++) begin
      check("R11 busy", 32'(inval_busy), 1);
      check("R11 clr", 32'(inval_clr), 1);
      check("R11 idx", 32'(inval_idx), 32'(i));
      if (i == 1) begin cfg_wr = 1; cfg_word = W_EN; end
      if (i == 3) begin
        exp_q.push_back(model(0, 0, 0, 2));   // R2: busy forces bypass
        req_valid = 1; req_instr = 0; req_write = 0; req_hit = 0;
      end
      @(negedge clk);
      cfg_wr = 0; req_valid = 0;
      if (i == 1) begin
        m_en = 1;
        check("R11 enable during walk cfg_err", 32'(cfg_err), 0);
      end
    end
    m_busy = 0;
    check("R11 busy fell", 32'(inval_busy), 0);
    check("R11 clr fell", 32'(inval_clr), 0);
    send(0, 0, 0, 11);                    // enabled after walk: allocates

    // R13: response lasts one cycle and queue drained
    @(negedge clk);
    check("R13 rsp_valid idle", 32'(rsp_valid), 0);
    check("R13 drained", 32'(exp_q.size()), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule